// File: doc/BRIEF.md
# Sequential Integer Divider with Processor Flag Quirks

This block is the division unit of a small 16-bit processor core. It takes a dividend, a divisor and a mode on a one-cycle `start_i` pulse. It then runs a restoring shift-and-subtract loop that produces one quotient bit per clock. When the loop ends it returns the quotient, the remainder, a divide-exception indication, a destination write enable and the six arithmetic flags. The flag values follow the rules of the processor family, not a generic definition.

Five operations are supported:
- unsigned and signed division of a 16-bit dividend by an 8-bit divisor;
- unsigned and signed division of a 32-bit dividend by a 16-bit divisor;
- a byte mode, in which the low dividend byte is divided by an 8-bit immediate.

The carry and overflow left by the most recent multiply are fed in with each request, because several modes pass them through to the flags. Two signed cases do not raise the exception a zero divisor would normally cause. Instead they return a fixed odd result: the most negative 16-bit dividend and the most negative 32-bit dividend, each divided by zero.

Top module: `quirk_divider`

## Requirements
- R1: `mode_i` codes are 0 = unsigned 16/8, 1 = signed 16/8, 2 = unsigned 32/16, 3 = signed 32/16, 4 = byte divide; codes 5 to 7 act as code 0. `flags_o` bits are [0] carry, [1] parity, [2] aux-carry, [3] zero, [4] sign, [5] overflow. A `start_i` seen while `busy_o` is low is accepted, and `busy_o` is high on the next cycle. `busy_o` stays high until the result is ready. `done_o` is then a single-cycle pulse with `busy_o` low. A `start_i` while `busy_o` is high is ignored.
- R2: Unsigned 16/8 (16-bit dividend in `dividend_i[15:0]`, divisor in `divisor_i[7:0]`) returns the quotient in `quot_o[7:0]` and the remainder in `rem_o[7:0]`, with the upper bytes zero. Aux-carry, parity and sign are 0. Carry and overflow equal the multiply flags given with the request. Zero is 1 only when the remainder is 0 and quotient bit 0 is 1.
- R3: Unsigned and signed 32/16 (32-bit dividend, divisor in `divisor_i[15:0]`) return a 16-bit quotient and a 16-bit remainder. All flags are 0 except zero, which follows the rule in R2.
- R4: Signed modes truncate the quotient toward zero, and the remainder takes the sign of the dividend.
- R5: Signed 16/8 clears carry, overflow and aux-carry. Parity (1 for an even number of ones), sign and zero are taken from the quotient byte.
- R6: An exception is raised when the divisor is zero, or when the quotient is outside the destination range. The ranges are 0..255 and 0..65535 for the unsigned modes, and -128..127 and -32768..32767 for the signed modes.
- R7: On a 16/8 exception, aux-carry, parity, sign and zero are 0, and carry and overflow equal the multiply flags. On a 32/16 exception all flags are 0.
- R8: Signed 16/8 with dividend 0x8000 and divisor 0 raises no exception and returns quotient byte 0x81 and remainder 0. Its flags follow R5.
- R9: Signed 32/16 with dividend 0x80000000 and divisor 0 raises no exception and returns quotient 0x8001 and remainder 0. Its flags follow R3.
- R10: Byte mode divides `dividend_i[7:0]` by `divisor_i[7:0]`. The quotient is in `quot_o[7:0]` and the remainder in `rem_o[7:0]`. Carry, overflow and aux-carry are 0; parity, sign and zero are taken from the remainder byte.
- R11: A byte-mode divide by zero raises an exception with aux-carry, parity and sign 0 and carry and overflow from the multiply flags. Zero is set when `dividend_i[7:0]` exceeds 0x3F.
- R12: `wr_en_o` is high only in the `done_o` cycle of an operation without an exception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a division |
| mode_i | input | 3 | Operation select (R1) |
| dividend_i | input | 32 | Dividend; low bits used by the narrow modes |
| divisor_i | input | 16 | Divisor or byte immediate |
| mul_cf_i | input | 1 | Carry left by the last multiply |
| mul_of_i | input | 1 | Overflow left by the last multiply |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid pulse |
| quot_o | output | 16 | Quotient |
| rem_o | output | 16 | Remainder |
| exc_o | output | 1 | Divide exception |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 6 | Updated flags |

## Verification
Assertions check the following on every cycle:
- the handshake: acceptance raises `busy_o`, a `done_o` pulse lasts one cycle, and the captured mode stays fixed while busy;
- `wr_en_o` is never high in an exception cycle;
- the partial remainder stays below the divisor during the loop;
- the flag rules that depend only on mode and outcome: wide modes clear carry and overflow, narrow exceptions pass through the multiply flags, and byte-mode zero tracks the remainder.

Only the bench scenarios can show the rest:
- the arithmetic values and the sign handling;
- the range limits at -128 and 128;
- the two fixed results for the most negative dividend divided by zero;
- the zero flag set above 0x3F on a byte divide by zero;
- a start request being ignored mid-operation.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;
  typedef enum logic [2:0] {
    MD_U16  = 3'd0,
    MD_S16  = 3'd1,
    MD_U32  = 3'd2,
    MD_S32  = 3'd3,
    MD_BYTE = 3'd4
  } qdiv_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } qdiv_state_e;

  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_AF = 2;
  localparam int FL_ZF = 3;
  localparam int FL_SF = 4;
  localparam int FL_OF = 5;
  localparam int FLW   = 6;
endpackage

// File: rtl/qdiv_prep.sv
module qdiv_prep
  import qdiv_pkg::*;
#(
  parameter  int QW  = 16,
  localparam int DVW = 2 * QW,
  localparam int CW  = $clog2(2 * QW + 1)
) (
  input  qdiv_mode_e       mode_i,
  input  logic [DVW-1:0]   dvd_i,
  input  logic [QW-1:0]    dvs_i,
  output logic [DVW-1:0]   mag_dvd_o,
  output logic [QW-1:0]    mag_dvs_o,
  output logic [CW-1:0]    nbits_o,
  output logic             q_neg_o,
  output logic             r_neg_o,
  output logic             dvs_zero_o,
  output logic             min_by_zero_o
);
  localparam int HW = QW / 2;

  logic [QW-1:0]  n_w, an_w, ad_w;
  logic [HW-1:0]  d_h, ad_h;
  logic [DVW-1:0] an_d;

  always_comb begin
    n_w  = dvd_i[QW-1:0];
    d_h  = dvs_i[HW-1:0];
    an_w = n_w[QW-1] ? -n_w : n_w;
    ad_h = d_h[HW-1] ? -d_h : d_h;
    an_d = dvd_i[DVW-1] ? -dvd_i : dvd_i;
    ad_w = dvs_i[QW-1] ? -dvs_i : dvs_i;

    q_neg_o   = 1'b0;
    r_neg_o   = 1'b0;
    nbits_o   = CW'(QW);
    mag_dvd_o = {n_w, {QW{1'b0}}};
    mag_dvs_o = {{(QW-HW){1'b0}}, d_h};
    unique case (mode_i)
      MD_S16: begin
        q_neg_o   = n_w[QW-1] ^ d_h[HW-1];
        r_neg_o   = n_w[QW-1];
        mag_dvd_o = {an_w, {QW{1'b0}}};
        mag_dvs_o = {{(QW-HW){1'b0}}, ad_h};
      end
      MD_U32: begin
        nbits_o   = CW'(DVW);
        mag_dvd_o = dvd_i;
        mag_dvs_o = dvs_i;
      end
      MD_S32: begin
        nbits_o   = CW'(DVW);
        q_neg_o   = dvd_i[DVW-1] ^ dvs_i[QW-1];
        r_neg_o   = dvd_i[DVW-1];
        mag_dvd_o = an_d;
        mag_dvs_o = ad_w;
      end
      MD_BYTE: begin
        nbits_o   = CW'(HW);
        mag_dvd_o = {dvd_i[HW-1:0], {(DVW-HW){1'b0}}};
      end
      default: ;
    endcase
  end

  assign dvs_zero_o    = (mag_dvs_o == '0);
  assign min_by_zero_o = ((mode_i == MD_S16) && (n_w == {1'b1, {(QW-1){1'b0}}}) && (d_h == '0))
                      || ((mode_i == MD_S32) && (dvd_i == {1'b1, {(DVW-1){1'b0}}}) && (dvs_i == '0));
endmodule

// File: rtl/qdiv_core.sv
module qdiv_core #(
  parameter  int QW  = 16,
  localparam int DVW = 2 * QW,
  localparam int CW  = $clog2(2 * QW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [DVW-1:0] dvd_i,
  input  logic [QW-1:0]  dvs_i,
  input  logic [CW-1:0]  nbits_i,
  output logic           run_o,
  output logic [DVW-1:0] quo_o,
  output logic [QW-1:0]  rem_o
);
  logic [QW-1:0]  rem_q, rem_d, dvs_q, dvs_d;
  logic [DVW-1:0] quo_q, quo_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [QW:0]    trial, diff;
  logic           en;

  assign run_o = (cnt_q != '0);
  assign en    = load_i | run_o;
  assign trial = {rem_q, quo_q[DVW-1]};
  assign diff  = trial - {1'b0, dvs_q};

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    dvs_d = dvs_q;
    cnt_d = cnt_q;
    if (load_i) begin
      rem_d = '0;
      quo_d = dvd_i;
      dvs_d = dvs_i;
      cnt_d = nbits_i;
    end else if (run_o) begin
      cnt_d = cnt_q - 1'b1;
      if (trial >= {1'b0, dvs_q}) begin
        rem_d = diff[QW-1:0];
        quo_d = {quo_q[DVW-2:0], 1'b1};
      end else begin
        rem_d = trial[QW-1:0];
        quo_d = {quo_q[DVW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/qdiv_finish.sv
module qdiv_finish
  import qdiv_pkg::*;
#(
  parameter  int QW  = 16,
  localparam int DVW = 2 * QW
) (
  input  qdiv_mode_e       mode_i,
  input  logic [DVW-1:0]   q_mag_i,
  input  logic [QW-1:0]    r_mag_i,
  input  logic             q_neg_i,
  input  logic             r_neg_i,
  input  logic             dvs_zero_i,
  input  logic             min_by_zero_i,
  input  logic             mul_cf_i,
  input  logic             mul_of_i,
  input  logic [QW/2-1:0]  low_byte_i,
  output logic [QW-1:0]    quot_o,
  output logic [QW-1:0]    rem_o,
  output logic             exc_o,
  output logic [FLW-1:0]   flags_o
);
  localparam int HW = QW / 2;
  localparam logic [DVW-1:0] HLIM = DVW'(1) << (HW - 1);
  localparam logic [DVW-1:0] WLIM = DVW'(1) << (QW - 1);
  localparam logic [HW-1:0]  HODD = {1'b1, {(HW-2){1'b0}}, 1'b1};
  localparam logic [QW-1:0]  WODD = {1'b1, {(QW-2){1'b0}}, 1'b1};

  logic [DVW-1:0] q_s;
  logic [QW-1:0]  r_s;
  logic           ovf, wide, narrow_exc_pass;

  assign q_s  = q_neg_i ? -q_mag_i : q_mag_i;
  assign r_s  = r_neg_i ? -r_mag_i : r_mag_i;
  assign wide = (mode_i == MD_U32) || (mode_i == MD_S32);

  always_comb begin
    unique case (mode_i)
      MD_U16:  ovf = |q_mag_i[DVW-1:HW];
      MD_U32:  ovf = |q_mag_i[DVW-1:QW];
      MD_S16:  ovf = q_mag_i > (q_neg_i ? HLIM : HLIM - 1'b1);
      MD_S32:  ovf = q_mag_i > (q_neg_i ? WLIM : WLIM - 1'b1);
      default: ovf = 1'b0;
    endcase
    exc_o = !min_by_zero_i && (dvs_zero_i || ovf);
    narrow_exc_pass = exc_o && !wide;

    if (wide) begin
      quot_o = q_s[QW-1:0];
      rem_o  = r_s;
    end else begin
      quot_o = {{(QW-HW){1'b0}}, q_s[HW-1:0]};
      rem_o  = {{(QW-HW){1'b0}}, r_s[HW-1:0]};
    end
    if (min_by_zero_i) begin
      quot_o = (mode_i == MD_S32) ? WODD : {{(QW-HW){1'b0}}, HODD};
      rem_o  = '0;
    end

    flags_o = '0;
    if (narrow_exc_pass) begin
      flags_o[FL_CF] = mul_cf_i;
      flags_o[FL_OF] = mul_of_i;
      flags_o[FL_ZF] = (mode_i == MD_BYTE) && (|low_byte_i[HW-1:HW-2]);
    end else if (!exc_o) begin
      unique case (mode_i)
        MD_S16: begin
          flags_o[FL_PF] = ~^quot_o[HW-1:0];
          flags_o[FL_SF] = quot_o[HW-1];
          flags_o[FL_ZF] = (quot_o[HW-1:0] == '0);
        end
        MD_BYTE: begin
          flags_o[FL_PF] = ~^rem_o[HW-1:0];
          flags_o[FL_SF] = rem_o[HW-1];
          flags_o[FL_ZF] = (rem_o[HW-1:0] == '0);
        end
        MD_U16: begin
          flags_o[FL_CF] = mul_cf_i;
          flags_o[FL_OF] = mul_of_i;
          flags_o[FL_ZF] = (rem_o == '0) && quot_o[0];
        end
        default: flags_o[FL_ZF] = (rem_o == '0) && quot_o[0];
      endcase
    end
  end
endmodule

// File: rtl/quirk_divider.sv
module quirk_divider
  import qdiv_pkg::*;
#(
  parameter  int QW  = 16,
  localparam int DVW = 2 * QW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [2:0]      mode_i,
  input  logic [DVW-1:0]  dividend_i,
  input  logic [QW-1:0]   divisor_i,
  input  logic            mul_cf_i,
  input  logic            mul_of_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [QW-1:0]   quot_o,
  output logic [QW-1:0]   rem_o,
  output logic            exc_o,
  output logic            wr_en_o,
  output logic [FLW-1:0]  flags_o
);
  localparam int HW = QW / 2;
  localparam int CW = $clog2(DVW + 1);

  logic [1:0]  rst_sync_q;
  logic        rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  qdiv_state_e state_q, state_d;
  qdiv_mode_e  mode_n, mode_q;
  logic        accept, finish;
  logic        cf_q, of_q, qneg_q, rneg_q, zero_q, mbz_q;
  logic [HW-1:0] lowb_q;

  logic [DVW-1:0] p_dvd, core_quo;
  logic [QW-1:0]  p_dvs, core_rem, f_quot, f_rem;
  logic [CW-1:0]  p_nbits;
  logic           p_qneg, p_rneg, p_zero, p_mbz, core_run, f_exc;
  logic [FLW-1:0] f_flags;

  assign mode_n = (mode_i > 3'd4) ? MD_U16 : qdiv_mode_e'(mode_i);
  assign accept = start_i && (state_q == ST_IDLE);
  assign finish = (state_q == ST_RUN) && !core_run;

  always_comb begin
    state_d = state_q;
    if (accept)      state_d = ST_RUN;
    else if (finish) state_d = ST_IDLE;
  end

  qdiv_prep #(.QW(QW)) u_prep (
    .mode_i(mode_n), .dvd_i(dividend_i), .dvs_i(divisor_i),
    .mag_dvd_o(p_dvd), .mag_dvs_o(p_dvs), .nbits_o(p_nbits),
    .q_neg_o(p_qneg), .r_neg_o(p_rneg), .dvs_zero_o(p_zero),
    .min_by_zero_o(p_mbz)
  );

  qdiv_core #(.QW(QW)) u_core (
    .clk(clk), .rst_n(rst_ns), .load_i(accept),
    .dvd_i(p_dvd), .dvs_i(p_dvs), .nbits_i(p_nbits),
    .run_o(core_run), .quo_o(core_quo), .rem_o(core_rem)
  );

  qdiv_finish #(.QW(QW)) u_finish (
    .mode_i(mode_q), .q_mag_i(core_quo), .r_mag_i(core_rem),
    .q_neg_i(qneg_q), .r_neg_i(rneg_q), .dvs_zero_i(zero_q),
    .min_by_zero_i(mbz_q), .mul_cf_i(cf_q), .mul_of_i(of_q),
    .low_byte_i(lowb_q), .quot_o(f_quot), .rem_o(f_rem),
    .exc_o(f_exc), .flags_o(f_flags)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      mode_q <= MD_U16;
      cf_q   <= 1'b0;
      of_q   <= 1'b0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      zero_q <= 1'b0;
      mbz_q  <= 1'b0;
      lowb_q <= '0;
    end else if (accept) begin
      mode_q <= mode_n;
      cf_q   <= mul_cf_i;
      of_q   <= mul_of_i;
      qneg_q <= p_qneg;
      rneg_q <= p_rneg;
      zero_q <= p_zero;
      mbz_q  <= p_mbz;
      lowb_q <= dividend_i[HW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      done_o  <= 1'b0;
      wr_en_o <= 1'b0;
    end else begin
      done_o  <= finish;
      wr_en_o <= finish && !f_exc;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      quot_o  <= '0;
      rem_o   <= '0;
      exc_o   <= 1'b0;
      flags_o <= '0;
    end else if (finish) begin
      quot_o  <= f_quot;
      rem_o   <= f_rem;
      exc_o   <= f_exc;
      flags_o <= f_flags;
    end
  end

  assign busy_o = (state_q == ST_RUN);

  // R1
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (start_i && !busy_o) |=> busy_o);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done_o |-> (!busy_o ##1 !done_o));
  // R1
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    busy_o |=> $stable(mode_q));
  // R12
  wr_en_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_en_o |-> (done_o && !exc_o));
  // R3
  wide_flags_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (done_o && (mode_q == MD_U32 || mode_q == MD_S32)) |->
      (flags_o[FL_CF] == 1'b0 && flags_o[FL_OF] == 1'b0 && flags_o[FL_SF] == 1'b0));
  // R7
  exc_mulflags_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (done_o && exc_o && (mode_q == MD_U16 || mode_q == MD_S16)) |->
      (flags_o[FL_CF] == cf_q && flags_o[FL_OF] == of_q && flags_o[FL_ZF] == 1'b0));
  // R10
  byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (done_o && !exc_o && mode_q == MD_BYTE) |-> (flags_o[FL_ZF] == (rem_o == '0)));
endmodule

// File: tb/quirk_divider_tb.sv
`timescale 1ns/1ps
module quirk_divider_tb;
  localparam int F_CF = 0, F_PF = 1, F_AF = 2, F_ZF = 3, F_SF = 4, F_OF = 5;

  typedef struct {
    logic [15:0] q;
    logic [15:0] r;
    logic        exc;
    logic        wr;
    logic [5:0]  fl;
    int          req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic [31:0] dividend_i = '0;
  logic [15:0] divisor_i = '0;
  logic        mul_cf_i = 1'b0;
  logic        mul_of_i = 1'b0;
  logic        busy_o, done_o, exc_o, wr_en_o;
  logic [15:0] quot_o, rem_o;
  logic [5:0]  flags_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  quirk_divider u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .mul_cf_i(mul_cf_i), .mul_of_i(mul_of_i),
    .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o), .rem_o(rem_o),
    .exc_o(exc_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  task automatic chk(input bit ok, input int req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input int md, input logic [31:0] n,
                                 input logic [15:0] d, input logic cf,
                                 input logic ovf, input int req);
    exp_t e;
    longint nn, dd, q, r, lo, hi;
    bit wide;
    e.q = '0; e.r = '0; e.exc = 1'b0; e.fl = '0; e.req = req;
    q = 0; r = 0;
    wide = (md == 2) || (md == 3);
    case (md)
      1: begin nn = longint'($signed(n[15:0])); dd = longint'($signed(d[7:0])); lo = -128; hi = 127; end
      2: begin nn = longint'(n); dd = longint'(d); lo = 0; hi = 65535; end
      3: begin nn = longint'($signed(n)); dd = longint'($signed(d)); lo = -32768; hi = 32767; end
      4: begin nn = longint'(n[7:0]); dd = longint'(d[7:0]); lo = 0; hi = 255; end
      default: begin nn = longint'(n[15:0]); dd = longint'(d[7:0]); lo = 0; hi = 255; end
    endcase
    if (md == 1 && n[15:0] == 16'h8000 && d[7:0] == 8'h00) begin
      e.q = 16'h0081;                               // R8
    end else if (md == 3 && n == 32'h8000_0000 && d == 16'h0000) begin
      e.q = 16'h8001;                               // R9
    end else if (dd == 0) begin
      e.exc = 1'b1;
    end else begin
      q = nn / dd;
      r = nn % dd;
      e.exc = (q < lo) || (q > hi);
      e.q = wide ? 16'(q) : {8'h00, 8'(q)};
      e.r = wide ? 16'(r) : {8'h00, 8'(r)};
    end
    if (e.exc) begin
      if (!wide) begin
        e.fl[F_CF] = cf;
        e.fl[F_OF] = ovf;
        e.fl[F_ZF] = (md == 4) && (n[7:0] > 8'h3F);
      end
    end else begin
      case (md)
        1: begin e.fl[F_PF] = ~^e.q[7:0]; e.fl[F_SF] = e.q[7]; e.fl[F_ZF] = (e.q[7:0] == 8'h00); end
        4: begin e.fl[F_PF] = ~^e.r[7:0]; e.fl[F_SF] = e.r[7]; e.fl[F_ZF] = (e.r[7:0] == 8'h00); end
        2, 3: e.fl[F_ZF] = (e.r == 16'h0) && e.q[0];
        default: begin
          e.fl[F_CF] = cf; e.fl[F_OF] = ovf;
          e.fl[F_ZF] = (e.r == 16'h0) && e.q[0];
        end
      endcase
    end
    e.wr = !e.exc;
    return e;
  endfunction

  task automatic issue(input int md, input logic [31:0] n, input logic [15:0] d,
                       input logic cf, input logic ovf, input int req);
    sb.push_back(model(md > 4 ? 0 : md, n, d, cf, ovf, req));
    @(negedge clk);
    start_i = 1'b1; mode_i = 3'(md); dividend_i = n; divisor_i = d;
    mul_cf_i = cf; mul_of_i = ovf;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, 1, "busy after start", longint'(busy_o), 1);  // R1
    while (!done_o) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, 1, "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(busy_o == 1'b0, 1, "busy low with done", longint'(busy_o), 0);
        chk(exc_o == e.exc, e.req, "exception", longint'(exc_o), longint'(e.exc));
        chk(wr_en_o == e.wr, 12, "write enable", longint'(wr_en_o), longint'(e.wr));
        chk(flags_o == e.fl, e.req, "flags", longint'(flags_o), longint'(e.fl));
        if (!e.exc) begin
          chk(quot_o == e.q, e.req, "quotient", longint'(quot_o), longint'(e.q));
          chk(rem_o == e.r, e.req, "remainder", longint'(rem_o), longint'(e.r));
        end
      end
    end
  end

  // Watchdog
  initial begin
    while (cycles < 60000) begin
      @(posedge clk);
      cycles++;
    end
    chk(1'b0, 1, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy_o == 1'b0, 1, "reset busy", longint'(busy_o), 0);
    chk(done_o == 1'b0, 1, "reset done", longint'(done_o), 0);
    chk(wr_en_o == 1'b0, 12, "reset wr_en", longint'(wr_en_o), 0);

    // R2 unsigned 16/8
    issue(0, 32'd100, 16'd7, 1'b1, 1'b0, 2);
    issue(0, 32'd15, 16'd3, 1'b0, 1'b1, 2);
    issue(0, 32'd16, 16'd4, 1'b1, 1'b1, 2);
    issue(0, 32'hFFFF_00FF, 16'hFF01, 1'b0, 1'b0, 2);  // upper bits unused
    issue(6, 32'd200, 16'd9, 1'b1, 1'b0, 1);           // R1 code 6 acts as 0
    // R6 unsigned range and zero divisor; R7 flags
    issue(0, 32'h1234, 16'h12, 1'b1, 1'b0, 6);
    issue(0, 32'h00FF, 16'h0, 1'b0, 1'b1, 7);
    issue(0, 32'h01FE, 16'h02, 1'b1, 1'b1, 6);
    // R4 R5 signed 16/8
    issue(1, 32'hFF9C, 16'd7, 1'b1, 1'b1, 4);
    issue(1, 32'd100, 16'hF9, 1'b0, 1'b0, 5);
    issue(1, 32'hFF00, 16'h02, 1'b0, 1'b0, 6);          // -128 fits
    issue(1, 32'h0100, 16'h02, 1'b1, 1'b0, 6);          // 128 overflows
    issue(1, 32'hFF00, 16'hFE, 1'b0, 1'b1, 6);          // +128 overflows
    issue(1, 32'h0005, 16'h00, 1'b1, 1'b1, 7);
    // R8 min by zero
    issue(1, 32'h8000, 16'h00, 1'b1, 1'b1, 8);
    // R3 32/16
    issue(2, 32'h0001_2345, 16'h0100, 1'b1, 1'b1, 3);
    issue(2, 32'd65535, 16'd65535, 1'b1, 1'b0, 3);
    issue(2, 32'h0001_0000, 16'h0001, 1'b1, 1'b1, 6);
    issue(3, 32'hFFFE_7960, 16'd7, 1'b1, 1'b1, 4);
    issue(3, 32'd99999, 16'hFFF9, 1'b0, 1'b0, 3);
    issue(3, 32'h8000_0000, 16'hFFFF, 1'b1, 1'b1, 7);
    issue(3, 32'hFFFF_8000, 16'h0001, 1'b0, 1'b0, 6);   // -32768 fits
    // R9 min by zero
    issue(3, 32'h8000_0000, 16'h0000, 1'b1, 1'b1, 9);
    // R10 byte mode
    issue(4, 32'h0000_12C8, 16'h0007, 1'b1, 1'b1, 10);
    issue(4, 32'h0000_0015, 16'h0003, 1'b1, 1'b0, 10);
    issue(4, 32'h0000_00FF, 16'h0080, 1'b0, 1'b0, 10);
    // R11 byte divide by zero
    issue(4, 32'h0000_0040, 16'h0000, 1'b1, 1'b0, 11);
    issue(4, 32'h0000_003F, 16'h0000, 1'b0, 1'b1, 11);

    // R1 start ignored while busy
    sb.push_back(model(0, 32'd250, 16'd10, 1'b0, 1'b0, 1));
    @(negedge clk);
    start_i = 1'b1; mode_i = 3'd0; dividend_i = 32'd250; divisor_i = 16'd10;
    mul_cf_i = 1'b0; mul_of_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; mode_i = 3'd4; dividend_i = 32'd77; divisor_i = 16'd0;
    mul_cf_i = 1'b1; mul_of_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(sb.size() == 0, 1, "pending results", longint'(sb.size()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule